// File: doc/BRIEF.md
# Control Register 4 Write Validator

This unit holds the fourth control register of a processor core: a 32-bit word of mode and feature enables. Each write arrives as a single-cycle strobe with the new word. The unit builds a mask of writable bits from a fixed base set and from four feature-presence inputs. A write that sets any bit outside that mask is refused. The register then keeps its old contents, and the unit raises a one-cycle rejection pulse that the core turns into a general-protection fault.

Writes that are accepted are compared with the old value on the bits that govern address translation. These are page-size extension (bit 4), physical-address extension (bit 5), global pages (bit 7), process-context identifiers (bit 17) and supervisor execution protection (bit 20). If any of them changes, the unit raises a one-cycle translation-cache flush request. Reloading the page-directory pointers and delivering the fault are left to neighbouring logic.

Top module: `cr4_guard`

## Requirements
- R1: After reset, the register reads zero and both pulse outputs are low.
- R2: A write whose set bits all lie within the writable mask is accepted: in the cycle after the strobe, the register equals the written word and no rejection pulse appears. With default parameters, bits 0 to 10 are always writable.
- R3: Bits 31 to 21 and bit 19 are never writable, and neither are bits 11 to 15 under the default base mask. A write that sets any of them is rejected: the register keeps its old value and the rejection pulse is high in the cycle after the strobe.
- R4: Bit 20 (supervisor execution protection) may be set only while `featSupExec` is high; otherwise the write is rejected.
- R5: Bit 18 (extended state save enable) may be set only while `featXsave` is high; otherwise the write is rejected.
- R6: Bit 17 (process-context identifier enable) may be set only while `featPcid` is high; otherwise the write is rejected.
- R7: Bit 16 (segment-base access instructions enable) may be set only while `featFsGsBase` is high; otherwise the write is rejected.
- R8: An accepted write that changes any of bits 4, 5, 7, 17 or 20 raises `tlbFlushReq` for exactly the cycle after the strobe.
- R9: No flush is requested for a rejected write, or for an accepted write that changes only other bits.
- R10: Both pulses last one cycle, never occur together, and appear only in the cycle after a write strobe. Back-to-back strobes are each judged against the value left by the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe, one cycle per write |
| wrData | input | 32 | Word to be written |
| featSupExec | input | 1 | Supervisor execution protection is implemented |
| featXsave | input | 1 | Extended state save is implemented |
| featPcid | input | 1 | Process-context identifiers are implemented |
| featFsGsBase | input | 1 | Segment-base access instructions are implemented |
| cr4Value | output | 32 | Current register contents |
| wrReject | output | 1 | One-cycle pulse: the previous write was refused |
| tlbFlushReq | output | 1 | One-cycle pulse: translation caches must be flushed |

## Verification
The hardest case to reach is a single accepted write that both clears a feature-gated bit and sets another one. That write must pass the feature gating and trigger the flush through a bit it removed rather than one it added. The register must first hold the old gated bit, so the stimulus runs a chain of writes in which each feature flag is raised for exactly one write. Each later write then drops the earlier gated bit while the earlier flag is already low. Back-to-back strobes check that every judgement uses the value just committed, not a stale one.

// File: rtl/cr4_guard_pkg.sv
package cr4_guard_pkg;

  // Feature-gated bit positions; index g pairs with feature input g.
  localparam int unsigned NUM_GATED = 4;
  localparam int unsigned GATED_POS [NUM_GATED] = '{20, 18, 17, 16};

  // Bits whose change invalidates cached translations.
  localparam int unsigned POS_PSE   = 4;
  localparam int unsigned POS_PAE   = 5;
  localparam int unsigned POS_PGE   = 7;
  localparam int unsigned POS_PCIDE = 17;
  localparam int unsigned POS_SEXEC = 20;

  typedef struct packed {
    logic commit;
    logic reject;
    logic flush;
  } wrStrobe_t;

endpackage

// File: rtl/cr4_guard_ctrl.sv
module cr4_guard_ctrl
  import cr4_guard_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter logic [REG_W-1:0] BASE_ALLOW = 32'h0000_07FF
) (
  input  logic                  wrEn,
  input  logic [REG_W-1:0]      wrData,
  input  logic [REG_W-1:0]      curValue,
  input  logic [NUM_GATED-1:0]  featVec,
  output wrStrobe_t             strobe
);

  localparam logic [REG_W-1:0] ONE = REG_W'(1);
  localparam logic [REG_W-1:0] FLUSH_MASK =
      (ONE << POS_PSE) | (ONE << POS_PAE) | (ONE << POS_PGE) |
      (ONE << POS_PCIDE) | (ONE << POS_SEXEC);

  logic [REG_W-1:0] gateBits [NUM_GATED];
  logic [REG_W-1:0] allowMask;
  logic             illegal;
  logic             touchesPaging;

  for (genvar g = 0; g < NUM_GATED; g++) begin : g_gate
    assign gateBits[g] = featVec[g] ? (ONE << GATED_POS[g]) : '0;
  end

  always_comb begin
    allowMask = BASE_ALLOW;
    for (int g = 0; g < NUM_GATED; g++) begin
      allowMask = allowMask | gateBits[g];
    end
  end

  always_comb begin
    illegal       = |(wrData & ~allowMask);
    touchesPaging = |((wrData ^ curValue) & FLUSH_MASK);
    strobe.commit = wrEn & ~illegal;
    strobe.reject = wrEn & illegal;
    strobe.flush  = wrEn & ~illegal & touchesPaging;
  end

endmodule

// File: rtl/cr4_guard_dp.sv
module cr4_guard_dp
  import cr4_guard_pkg::*;
#(
  parameter int unsigned REG_W = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  wrStrobe_t        strobe,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] value,
  output logic             rejectQ,
  output logic             flushQ
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      value   <= '0;
      rejectQ <= 1'b0;
      flushQ  <= 1'b0;
    end else begin
      if (strobe.commit) value <= wrData;
      rejectQ <= strobe.reject;
      flushQ  <= strobe.flush;
    end
  end

endmodule

// File: rtl/cr4_guard.sv
module cr4_guard
  import cr4_guard_pkg::*;
#(
  parameter int unsigned REG_W      = 32,
  parameter logic [REG_W-1:0] BASE_ALLOW = 32'h0000_07FF
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  input  logic             featSupExec,
  input  logic             featXsave,
  input  logic             featPcid,
  input  logic             featFsGsBase,
  output logic [REG_W-1:0] cr4Value,
  output logic             wrReject,
  output logic             tlbFlushReq
);

  wrStrobe_t            strobe;
  logic [NUM_GATED-1:0] featVec;

  assign featVec = {featFsGsBase, featPcid, featXsave, featSupExec};

  cr4_guard_ctrl #(.REG_W(REG_W), .BASE_ALLOW(BASE_ALLOW)) i_ctrl (
    .wrEn    (wrEn),
    .wrData  (wrData),
    .curValue(cr4Value),
    .featVec (featVec),
    .strobe  (strobe)
  );

  cr4_guard_dp #(.REG_W(REG_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .wrData (wrData),
    .value  (cr4Value),
    .rejectQ(wrReject),
    .flushQ (tlbFlushReq)
  );

endmodule

// File: rtl/cr4_guard_chk.sv
module cr4_guard_chk #(
  parameter int unsigned REG_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [REG_W-1:0] wrData,
  input logic             featSupExec,
  input logic             featXsave,
  input logic             featPcid,
  input logic             featFsGsBase,
  input logic [REG_W-1:0] cr4Value,
  input logic             wrReject,
  input logic             tlbFlushReq
);

  localparam logic [REG_W-1:0] PAGING_BITS = REG_W'(32'h0012_00B0);

  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rstN)
    (cr4Value[REG_W-1:21] == '0) && !cr4Value[19]);

  assert_reject_keeps_R3: assert property (@(posedge clk) disable iff (!rstN)
    wrReject |-> (cr4Value == $past(cr4Value)));

  assert_accept_loads_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && !wrReject) |-> (cr4Value == $past(wrData)));

  assert_supexec_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cr4Value[20]) |-> $past(featSupExec));

  assert_xsave_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cr4Value[18]) |-> $past(featXsave));

  assert_pcid_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cr4Value[17]) |-> $past(featPcid));

  assert_fsgs_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cr4Value[16]) |-> $past(featFsGsBase));

  assert_flush_cause_R8: assert property (@(posedge clk) disable iff (!rstN)
    tlbFlushReq |-> (((cr4Value ^ $past(cr4Value)) & PAGING_BITS) != '0));

  assert_flush_missing_R9: assert property (@(posedge clk) disable iff (!rstN)
    ($past(wrEn) && !wrReject && (((cr4Value ^ $past(cr4Value)) & PAGING_BITS) != '0))
      |-> tlbFlushReq);

  assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    !(wrReject && tlbFlushReq));

  assert_pulse_source_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrReject || tlbFlushReq) |-> $past(wrEn));

endmodule

bind cr4_guard cr4_guard_chk #(.REG_W(REG_W)) i_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wrEn        (wrEn),
  .wrData      (wrData),
  .featSupExec (featSupExec),
  .featXsave   (featXsave),
  .featPcid    (featPcid),
  .featFsGsBase(featFsGsBase),
  .cr4Value    (cr4Value),
  .wrReject    (wrReject),
  .tlbFlushReq (tlbFlushReq)
);

// File: tb/test_cr4_guard.sv
module test_cr4_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [3:0]  feat = '0;   // [3]=supExec [2]=xsave [1]=pcid [0]=fsgsbase
  logic [31:0] cr4Value;
  logic        wrReject;
  logic        tlbFlushReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;

  cr4_guard i_cr4_guard (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrData      (wrData),
    .featSupExec (feat[3]),
    .featXsave   (feat[2]),
    .featPcid    (feat[1]),
    .featFsGsBase(feat[0]),
    .cr4Value    (cr4Value),
    .wrReject    (wrReject),
    .tlbFlushReq (tlbFlushReq)
  );

  // {feat, data, expected value, expected reject, expected flush}
  localparam int NV = 16;
  localparam logic [69:0] VEC [NV] = '{
    {4'h0, 32'h0000_00A0, 32'h0000_00A0, 1'b0, 1'b1}, // R2 R8 paging bits set
    {4'h0, 32'h0000_00A3, 32'h0000_00A3, 1'b0, 1'b0}, // R9 non-paging change
    {4'h0, 32'h0010_00A3, 32'h0000_00A3, 1'b1, 1'b0}, // R4 gated off
    {4'h8, 32'h0010_00A3, 32'h0010_00A3, 1'b0, 1'b1}, // R4 gated on
    {4'h0, 32'h0004_00A3, 32'h0010_00A3, 1'b1, 1'b0}, // R5 gated off
    {4'h4, 32'h0004_00A3, 32'h0004_00A3, 1'b0, 1'b1}, // R5 on, clears bit 20
    {4'h0, 32'h0002_0000, 32'h0004_00A3, 1'b1, 1'b0}, // R6 gated off
    {4'h2, 32'h0002_0000, 32'h0002_0000, 1'b0, 1'b1}, // R6 gated on
    {4'h0, 32'h0001_0000, 32'h0002_0000, 1'b1, 1'b0}, // R7 gated off
    {4'h1, 32'h0001_0000, 32'h0001_0000, 1'b0, 1'b1}, // R7 on, clears bit 17
    {4'hF, 32'h8001_0000, 32'h0001_0000, 1'b1, 1'b0}, // R3 bit 31
    {4'hF, 32'h0009_0000, 32'h0001_0000, 1'b1, 1'b0}, // R3 bit 19
    {4'hF, 32'h0001_0800, 32'h0001_0000, 1'b1, 1'b0}, // R3 bit 11
    {4'hF, 32'h0001_0010, 32'h0001_0010, 1'b0, 1'b1}, // R8 bit 4
    {4'hF, 32'h0001_0210, 32'h0001_0210, 1'b0, 1'b0}, // R9 bit 9 only
    {4'hF, 32'h0000_0210, 32'h0000_0210, 1'b0, 1'b0}  // R9 bit 16 only
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic doWrite(input logic [3:0] f, input logic [31:0] d);
    feat   = f;
    wrData = d;
    wrEn   = 1'b1;
    @(negedge clk);
    wrEn   = 1'b0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd0, 32'd1);
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 value", cr4Value, 32'h0);
    check("R1 reject", {31'b0, wrReject}, 32'h0);
    check("R1 flush", {31'b0, tlbFlushReq}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      doWrite(VEC[i][69:66], VEC[i][65:34]);
      check("R2/R3 value", cr4Value, VEC[i][33:2]);
      check("R3/R4 reject", {31'b0, wrReject}, {31'b0, VEC[i][1]});
      check("R8/R9 flush", {31'b0, tlbFlushReq}, {31'b0, VEC[i][0]});
    end

    // R10: pulses drop after one cycle of idle
    doWrite(4'h0, 32'h8000_0000);
    check("R10 reject pulse", {31'b0, wrReject}, 32'h1);
    @(negedge clk);
    check("R10 reject single", {31'b0, wrReject}, 32'h0);
    doWrite(4'h0, 32'h0000_0230);
    check("R10 flush pulse", {31'b0, tlbFlushReq}, 32'h1);
    @(negedge clk);
    check("R10 flush single", {31'b0, tlbFlushReq}, 32'h0);

    // R10: back-to-back writes judged against freshly committed value
    doWrite(4'h8, 32'h0010_0230);
    check("R10 b2b first flush", {31'b0, tlbFlushReq}, 32'h1);
    doWrite(4'h0, 32'h0000_0230);
    check("R10 b2b drop bit20 value", cr4Value, 32'h0000_0230);
    check("R10 b2b drop bit20 flush", {31'b0, tlbFlushReq}, 32'h1);
    doWrite(4'h0, 32'h0000_0230);
    check("R9 b2b same value flush", {31'b0, tlbFlushReq}, 32'h0);
    check("R9 b2b same value reject", {31'b0, wrReject}, 32'h0);

    // R1: reset from a non-zero state
    rstN = 1'b0;
    @(negedge clk);
    check("R1 rereset value", cr4Value, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after release", cr4Value, 32'h0);

    finishRun();
  end

endmodule